// File: doc/BRIEF.md
# OTP Command Register Controller

This block is the register front end of a secure-boot controller. A host reaches it through a simple 32-bit register bus with byte addresses. Alongside plain storage registers, it holds a command register. Writing one of two fixed 32-bit key words to that register starts an operation on an internal one-time-programmable (OTP) word array. The operation is either a fetch into the compare registers or a store taken from the first compare register. The OTP word address comes from the address register.

OTP word addresses split into three ranges. Addresses below `DATA_WORDS` form the data range. A fetch there returns a pair of neighbouring words. Addresses from `DATA_WORDS` up to `TOTAL_WORDS - 1` form the configuration range, and a fetch there returns a single word. Any higher address is refused.

While an operation runs, two idle flags in the status register drop and a busy output rises. Both return when the operation ends, whether it succeeded or was refused. A signing-settings word is captured from an input pin while reset is held, and software can only read it.

The array model keeps `STORE_WORDS` physical words, which must be a power of two. Each OTP address selects the entry given by its low bits.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset every register reads zero, except two. The status register (byte offset 0x014) reads 0x0000_0006, which has bit 2 (controller idle) and bit 1 (array idle) set. The signing-settings register (offset 0x040) reads the value that `sign_cfg` held during reset.
- R2: Writing 0x23B1E361 to the command register (offset 0x004) starts a fetch. When the address register (0x010) holds N < `DATA_WORDS`, the fetch loads word N into compare-1 (0x020) and word N+1 into compare-2 (0x024).
- R3: A fetch at an address N with `DATA_WORDS` <= N < `TOTAL_WORDS` loads word N into compare-1 and leaves compare-2 unchanged. The lowest such address, `DATA_WORDS`, belongs to this range.
- R4: A fetch or a store at an address of `TOTAL_WORDS` or above changes neither compare register and no array word. The idle flags still return afterwards.
- R5: Writing 0x23B1E364 to the command register stores the current compare-1 value into array word N, where N is the value in the address register.
- R6: A command-register write with any other value starts nothing. Busy stays low, the status is unchanged and no register changes.
- R7: After an accepted command write, status bits 2 and 1 read zero and `cmd_busy` is high for exactly two cycles. Both bits then read one again.
- R8: A command-register write made while `cmd_busy` is high is ignored and does not extend the busy window.
- R9: Bus writes to the status register and to the signing-settings register have no effect.
- R10: Reads of the command register, of unmapped word offsets, and of any byte address whose two low bits are not zero all return zero. Writes to such addresses change nothing.
- R11: The protection (0x000), address, compare-1 and compare-2 registers read back the last 32-bit value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sign_cfg | input | 32 | Signing-settings value captured during reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | BUS_AW | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` while a read is strobed |
| cmd_busy | output | 1 | High while an OTP command is in progress |

## Verification
The fetch path is tested with addresses from four groups: deep inside the data range, the first configuration address, inside the configuration range, and beyond the top of the array. Each group shows whether the range decode picks the one-word or two-word result, or refuses the access. Stores are followed by fetches at the same address, which confirms where a stored word lands. A refused store is followed by a fetch at an in-range address that shares its low bits, which shows that the refusal really blocked the write. Key words that are wrong by a single value, and a second command written during the busy window, check that only an exact key on an idle controller starts an operation.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;

  // Word indices inside the register window (byte offset / 4)
  localparam int IDX_PROT = 'h000;
  localparam int IDX_CMD  = 'h001;
  localparam int IDX_ADDR = 'h004;
  localparam int IDX_STAT = 'h005;
  localparam int IDX_CMP1 = 'h008;
  localparam int IDX_CMP2 = 'h009;
  localparam int IDX_SIGN = 'h010;

  localparam logic [31:0] KEY_FETCH = 32'h23B1_E361;
  localparam logic [31:0] KEY_STORE = 32'h23B1_E364;

  // status bit 2: controller idle, bit 1: array idle
  localparam logic [31:0] IDLE_MASK = 32'h0000_0006;

  typedef enum logic [1:0] {OP_NONE, OP_FETCH, OP_STORE} op_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ACCESS, SEQ_DONE} seq_e;
  typedef enum logic [1:0] {RGN_DATA, RGN_CFG, RGN_BAD} rgn_e;

  function automatic op_e decode_key(input logic [31:0] w);
    if (w == KEY_FETCH) return OP_FETCH;
    if (w == KEY_STORE) return OP_STORE;
    return OP_NONE;
  endfunction

  function automatic rgn_e classify(input logic [31:0] a,
                                    input int unsigned data_words,
                                    input int unsigned total_words);
    if (a < 32'(data_words)) return RGN_DATA;
    if (a < 32'(total_words)) return RGN_CFG;
    return RGN_BAD;
  endfunction

endpackage

// File: rtl/otp_word_array.sv
module otp_word_array #(
  parameter int WORD_W      = 32,
  parameter int STORE_WORDS = 64,
  localparam int IDX_W      = $clog2(STORE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word0,
  output logic [WORD_W-1:0] rd_word1,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] cells [STORE_WORDS];
  logic [IDX_W-1:0]  nxt_idx;

  assign nxt_idx  = rd_idx + 1'b1;
  assign rd_word0 = cells[rd_idx];
  assign rd_word1 = cells[nxt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_WORDS; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[wr_idx] <= wr_data;
    end
  end

  // R5: a store lands in the addressed cell
  p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_ctrl_pkg::*;
#(
  parameter int DATA_WORDS  = 2048,
  parameter int TOTAL_WORDS = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic [31:0] addr_in,
  output logic        busy,
  output logic        start,
  output logic        done,
  output logic        ld_cmp1,
  output logic        ld_cmp2,
  output logic        store_en,
  output logic        refuse,
  output logic [31:0] addr_q
);
  seq_e st_q;
  op_e  op_q;
  op_e  cmd_op;
  rgn_e rgn_q;
  logic access;

  assign cmd_op   = decode_key(cmd_word);
  assign start    = cmd_wr && (cmd_op != OP_NONE) && (st_q == SEQ_IDLE);
  assign busy     = (st_q != SEQ_IDLE);
  assign access   = (st_q == SEQ_ACCESS);
  assign done     = (st_q == SEQ_DONE);
  assign refuse   = access && (rgn_q == RGN_BAD);
  assign ld_cmp1  = access && (op_q == OP_FETCH) && (rgn_q != RGN_BAD);
  assign ld_cmp2  = access && (op_q == OP_FETCH) && (rgn_q == RGN_DATA);
  assign store_en = access && (op_q == OP_STORE) && (rgn_q != RGN_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      op_q   <= OP_NONE;
      rgn_q  <= RGN_DATA;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start) begin
          st_q   <= SEQ_ACCESS;
          op_q   <= cmd_op;
          addr_q <= addr_in;
          rgn_q  <= classify(addr_in, DATA_WORDS, TOTAL_WORDS);
        end
        SEQ_ACCESS: st_q <= SEQ_DONE;
        SEQ_DONE: begin
          st_q <= SEQ_IDLE;
          op_q <= OP_NONE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  // R7: busy window is exactly two cycles
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy ##1 busy ##1 !busy);

  // R8: a command during busy does not relatch the operation
  p_no_relatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && cmd_wr) |=> ($stable(addr_q) && $stable(op_q)));

  // R4: refused access never loads or stores
  p_refuse_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |-> !(ld_cmp1 || ld_cmp2 || store_en));

endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_ctrl_pkg::*;
#(
  parameter int DATA_WORDS  = 2048,
  parameter int TOTAL_WORDS = 4096,
  parameter int STORE_WORDS = 64,
  parameter int BUS_AW      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       sign_cfg,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_busy
);
  localparam int WIDX_W = BUS_AW - 2;
  localparam int SIDX_W = $clog2(STORE_WORDS);

  logic [WIDX_W-1:0] widx;
  logic aligned, wr, rd;
  logic wr_prot, wr_cmd, wr_addr, wr_cmp1, wr_cmp2;
  logic [31:0] prot_q, otp_addr_q, status_q, cmp1_q, cmp2_q, sign_q;
  logic [31:0] seq_addr, arr_w0, arr_w1;
  logic start, done, ld_cmp1, ld_cmp2, store_en, refuse;

  function automatic logic hit(input logic [WIDX_W-1:0] w, input int k);
    return w == WIDX_W'(k);
  endfunction

  assign widx    = bus_addr[BUS_AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_en && bus_we && aligned;
  assign rd      = bus_en && !bus_we && aligned;
  assign wr_prot = wr && hit(widx, IDX_PROT);
  assign wr_cmd  = wr && hit(widx, IDX_CMD);
  assign wr_addr = wr && hit(widx, IDX_ADDR);
  assign wr_cmp1 = wr && hit(widx, IDX_CMP1);
  assign wr_cmp2 = wr && hit(widx, IDX_CMP2);

  otp_cmd_seq #(.DATA_WORDS(DATA_WORDS), .TOTAL_WORDS(TOTAL_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(wr_cmd), .cmd_word(bus_wdata), .addr_in(otp_addr_q),
    .busy(cmd_busy), .start(start), .done(done),
    .ld_cmp1(ld_cmp1), .ld_cmp2(ld_cmp2), .store_en(store_en),
    .refuse(refuse), .addr_q(seq_addr)
  );

  otp_word_array #(.WORD_W(32), .STORE_WORDS(STORE_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(seq_addr[SIDX_W-1:0]), .rd_word0(arr_w0), .rd_word1(arr_w1),
    .wr_en(store_en), .wr_idx(seq_addr[SIDX_W-1:0]), .wr_data(cmp1_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q     <= '0;
      otp_addr_q <= '0;
      cmp1_q     <= '0;
      cmp2_q     <= '0;
      status_q   <= IDLE_MASK;
    end else begin
      if (wr_prot) prot_q <= bus_wdata;
      if (wr_addr) otp_addr_q <= bus_wdata;
      if (ld_cmp1)      cmp1_q <= arr_w0;
      else if (wr_cmp1) cmp1_q <= bus_wdata;
      if (ld_cmp2)      cmp2_q <= arr_w1;
      else if (wr_cmp2) cmp2_q <= bus_wdata;
      if (start)     status_q <= status_q & ~IDLE_MASK;
      else if (done) status_q <= status_q | IDLE_MASK;
    end
  end

  // signing settings follow the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) sign_q <= sign_cfg;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit(widx, IDX_PROT))      bus_rdata = prot_q;
      else if (hit(widx, IDX_ADDR)) bus_rdata = otp_addr_q;
      else if (hit(widx, IDX_STAT)) bus_rdata = status_q;
      else if (hit(widx, IDX_CMP1)) bus_rdata = cmp1_q;
      else if (hit(widx, IDX_CMP2)) bus_rdata = cmp2_q;
      else if (hit(widx, IDX_SIGN)) bus_rdata = sign_q;
    end
  end

  // R7: idle flags drop after start and return after completion
  p_start_clears_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((status_q & IDLE_MASK) == 32'h0));
  p_done_sets_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((status_q & IDLE_MASK) == IDLE_MASK));

  // R9: status moves only with the sequencer, signing settings never after reset
  p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done) |=> $stable(status_q));
  p_sign_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(sign_q));

  // R4: refused access leaves both compare registers alone
  p_refuse_keeps_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !wr_cmp1 && !wr_cmp2) |=> ($stable(cmp1_q) && $stable(cmp2_q)));

  // R3: a single-word fetch keeps compare-2
  p_single_keeps_cmp2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cmp1 && !ld_cmp2 && !wr_cmp2) |=> $stable(cmp2_q));

endmodule

// File: tb/otp_cmd_ctrl_test.sv
module otp_cmd_ctrl_test;
  localparam logic [11:0] A_PROT = 12'h000, A_CMD = 12'h004, A_ADDR = 12'h010,
                          A_STAT = 12'h014, A_CMP1 = 12'h020, A_CMP2 = 12'h024,
                          A_SIGN = 12'h040;
  localparam logic [31:0] K_FETCH = 32'h23B1_E361, K_STORE = 32'h23B1_E364;
  localparam logic [31:0] SIGN_VAL = 32'h0000_3C00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_busy;
  int n_chk = 0, n_fail = 0;

  otp_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sign_cfg(SIGN_VAL),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_busy(cmd_busy)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  // issue a key word and follow the idle flags through the busy window
  task automatic run_cmd(input logic [31:0] key);
    bus_wr(A_CMD, key);
    read_check("R7 idle low cycle 1", A_STAT, 32'h0);
    check("R7 busy cycle 1", {31'b0, cmd_busy}, 32'h1);
    @(negedge clk);
    check("R7 busy cycle 2", {31'b0, cmd_busy}, 32'h1);
    @(negedge clk);
    check("R7 busy released", {31'b0, cmd_busy}, 32'h0);
    read_check("R7 idle restored", A_STAT, 32'h6);
  endtask

  task automatic t_reset;
    read_check("R1 prot", A_PROT, 32'h0);
    read_check("R1 addr", A_ADDR, 32'h0);
    read_check("R1 status", A_STAT, 32'h6);
    read_check("R1 cmp1", A_CMP1, 32'h0);
    read_check("R1 cmp2", A_CMP2, 32'h0);
    read_check("R1 sign", A_SIGN, SIGN_VAL);
    check("R1 busy", {31'b0, cmd_busy}, 32'h0);
  endtask

  task automatic t_plain_regs;
    bus_wr(A_PROT, 32'hDEAD_0001);
    bus_wr(A_CMP1, 32'h1234_5678);
    bus_wr(A_CMP2, 32'h8765_4321);
    bus_wr(A_ADDR, 32'h0000_0ABC);
    read_check("R11 prot", A_PROT, 32'hDEAD_0001);
    read_check("R11 cmp1", A_CMP1, 32'h1234_5678);
    read_check("R11 cmp2", A_CMP2, 32'h8765_4321);
    read_check("R11 addr", A_ADDR, 32'h0000_0ABC);
  endtask

  task automatic t_read_only;
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    read_check("R9 status write ignored", A_STAT, 32'h6);
    bus_wr(A_SIGN, 32'h0000_0000);
    read_check("R9 sign write ignored", A_SIGN, SIGN_VAL);
  endtask

  task automatic t_unmapped;
    bus_wr(12'h008, 32'hCAFE_CAFE);
    read_check("R10 unmapped reads zero", 12'h008, 32'h0);
    read_check("R10 other offset zero", 12'h030, 32'h0);
    read_check("R10 command reads zero", A_CMD, 32'h0);
    bus_wr(12'h021, 32'h5555_5555);
    read_check("R10 misaligned write ignored", A_CMP1, 32'h1234_5678);
    read_check("R10 misaligned read zero", 12'h001, 32'h0);
    read_check("R10 prot untouched", A_PROT, 32'hDEAD_0001);
  endtask

  task automatic t_data_range;
    bus_wr(A_CMP1, 32'hA5A5_0010); bus_wr(A_ADDR, 32'h10); run_cmd(K_STORE);
    bus_wr(A_CMP1, 32'hA5A5_0011); bus_wr(A_ADDR, 32'h11); run_cmd(K_STORE);
    bus_wr(A_CMP1, 32'h0); bus_wr(A_CMP2, 32'h0);
    bus_wr(A_ADDR, 32'h10); run_cmd(K_FETCH);
    read_check("R2 R5 word N", A_CMP1, 32'hA5A5_0010);
    read_check("R2 R5 word N+1", A_CMP2, 32'hA5A5_0011);
  endtask

  task automatic t_cfg_range;
    bus_wr(A_CMP1, 32'hC0F1_0805); bus_wr(A_ADDR, 32'h805); run_cmd(K_STORE);
    bus_wr(A_CMP1, 32'h0); bus_wr(A_CMP2, 32'h0BAD_F00D);
    run_cmd(K_FETCH);
    read_check("R3 R5 cfg word", A_CMP1, 32'hC0F1_0805);
    read_check("R3 cmp2 kept", A_CMP2, 32'h0BAD_F00D);
    bus_wr(A_CMP1, 32'h7777_7777); bus_wr(A_ADDR, 32'h800); run_cmd(K_FETCH);
    read_check("R3 boundary cmp1 from word 0x800", A_CMP1, 32'h0);
    read_check("R3 boundary cmp2 kept", A_CMP2, 32'h0BAD_F00D);
  endtask

  task automatic t_out_of_range;
    bus_wr(A_CMP1, 32'h1111_1111); bus_wr(A_CMP2, 32'h2222_2222);
    bus_wr(A_ADDR, 32'h1003); run_cmd(K_FETCH);
    read_check("R4 fetch cmp1 kept", A_CMP1, 32'h1111_1111);
    read_check("R4 fetch cmp2 kept", A_CMP2, 32'h2222_2222);
    run_cmd(K_STORE);
    bus_wr(A_ADDR, 32'h803); run_cmd(K_FETCH);
    read_check("R4 refused store left array", A_CMP1, 32'h0);
  endtask

  task automatic t_bad_key;
    bus_wr(A_CMP1, 32'h3333_3333); bus_wr(A_CMP2, 32'h4444_4444);
    bus_wr(A_ADDR, 32'h10);
    bus_wr(A_CMD, 32'h23B1_E362);
    check("R6 no busy", {31'b0, cmd_busy}, 32'h0);
    read_check("R6 status idle", A_STAT, 32'h6);
    @(negedge clk); @(negedge clk);
    read_check("R6 cmp1 unchanged", A_CMP1, 32'h3333_3333);
    read_check("R6 cmp2 unchanged", A_CMP2, 32'h4444_4444);
  endtask

  task automatic t_busy_ignore;
    bus_wr(A_CMP1, 32'h0); bus_wr(A_CMP2, 32'h0);
    bus_wr(A_ADDR, 32'h10);
    bus_wr(A_CMD, K_FETCH);
    check("R8 first accepted", {31'b0, cmd_busy}, 32'h1);
    bus_wr(A_CMD, K_STORE);
    check("R8 second ignored, no extension", {31'b0, cmd_busy}, 32'h0);
    read_check("R8 idle after window", A_STAT, 32'h6);
    read_check("R8 result from first", A_CMP1, 32'hA5A5_0010);
    read_check("R8 second pair word", A_CMP2, 32'hA5A5_0011);
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_regs();
    t_read_only();
    t_unmapped();
    t_data_range();
    t_cfg_range();
    t_out_of_range();
    t_bad_key();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule